// File: doc/BRIEF.md
# Power-Management Status and Control Register

This block is one 8-bit status and control register for the power-management unit of a small microcontroller. It keeps two sticky flags. The first records that the supply has dropped below its warning threshold. The second records that the device has just woken from the partial power-down mode. Each flag has its own write-one acknowledge bit. The register also holds two write-once configuration bits. One enables the power-down modes. The other picks the power-down depth.

The CPU reaches the register through a simple bus: a decode strobe, a write enable, write data and combinational read data. The low-voltage level comes from an analog comparator and is asynchronous, so it passes through a two-flop synchronizer before it is used. The exit event comes from the stop-mode sequencer as a one-cycle pulse in the register's clock domain. The two configuration outputs feed that sequencer.

Top module: `pmu_stat_ctrl`

## Requirements
- R1: While `lvw_i` is held high, bit 7 (warning flag) reads 1 no later than the third rising clock edge after `lvw_i` went high. This allows for the two synchronizer stages.
- R2: The warning flag stays 1 after `lvw_i` returns low, until it is acknowledged.
- R3: A write with bit 6 = 1 clears the warning flag only when the synchronized warning level is low. While that level is high, the flag stays 1.
- R4: After reset, all readable bits are 0. The one exception is the warning flag: it reads 1 within three clock edges if `lvw_i` is held high through and after reset.
- R5: A one-cycle pulse on `ppd_exit_i` sets bit 3 (partial power-down flag). The flag stays set with no further pulses.
- R6: A write with bit 2 = 1 clears the partial power-down flag. If a `ppd_exit_i` pulse arrives in the same cycle, the flag stays 1.
- R7: The first write after reset loads bit 1 into `pd_en_o` and bit 0 into `pd_mode_o`, whatever the values written.
- R8: Every later write leaves `pd_en_o` and `pd_mode_o` unchanged until the next reset.
- R9: Read data layout when `sel_i` is high: bit 7 warning flag, bit 3 partial power-down flag, bit 1 power-down enable, bit 0 mode select. Bits 6, 5, 4 and 2 read 0. When `sel_i` is low, `rdata_o` is 0.
- R10: Writing 1 to bit 7 or bit 3 does not set either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register select from the address decoder |
| we_i | input | 1 | Write enable, qualified by `sel_i` |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not selected |
| lvw_i | input | 1 | Asynchronous low-voltage warning level |
| ppd_exit_i | input | 1 | One-cycle pulse on exit from partial power-down |
| pd_en_o | output | 1 | Power-down modes enabled |
| pd_mode_o | output | 1 | 1 selects partial power-down, 0 selects full |

## Verification
Directed sequences separate the cases that matter here. One acknowledges the warning while the synchronized level is still high and then again once it is low. Another lands an exit pulse in the same cycle as its acknowledge. Writes of all ones and all zeros show that the write-once latch does not depend on the value written. Resetting with the warning held high covers the case where the flag comes out of reset set. A random phase with a fixed seed then holds the warning level for random stretches, scatters exit pulses, and mixes reads, writes and deselected cycles. A cycle model in the bench, which tracks the two-stage delay, tells a missing or extra synchronizer stage apart from a wrong priority between set and clear.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int REG_W     = 8;
  localparam int WFLAG_BIT = 7;
  localparam int WACK_BIT  = 6;
  localparam int PFLAG_BIT = 3;
  localparam int PACK_BIT  = 2;
  localparam int PDEN_BIT  = 1;
  localparam int PMODE_BIT = 0;
  localparam int SYNC_DEF  = 2;
endpackage

// File: rtl/pmu_sync.sv
module pmu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pmu_sticky.sv
module pmu_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/pmu_wonce.sv
module pmu_wonce (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic d_i,
  output logic q_o,
  output logic locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o      <= 1'b0;
      locked_o <= 1'b0;
    end else if (wr_i && !locked_o) begin
      q_o      <= d_i;
      locked_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pmu_stat_ctrl.sv
module pmu_stat_ctrl
  import pmu_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_DEF,
  parameter int NUM_CFG     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             lvw_i,
  input  logic             ppd_exit_i,
  output logic             pd_en_o,
  output logic             pd_mode_o
);
  localparam int CFG_LSB = PMODE_BIT;

  logic               wr;
  logic               lvw_sync;
  logic               warn_q;
  logic               ppd_q;
  logic [NUM_CFG-1:0] cfg_q;
  logic [NUM_CFG-1:0] cfg_lock;
  logic [REG_W-1:0]   reg_val;
  logic               unused_wdata;

  assign wr = sel_i & we_i;
  assign unused_wdata = ^{wdata_i[WFLAG_BIT], wdata_i[5:4], wdata_i[PFLAG_BIT]};

  pmu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lvw_i),
    .q_o   (lvw_sync)
  );

  // level-driven set: ack can only win once the level is gone
  pmu_sticky u_warn (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (lvw_sync),
    .clr_i (wr & wdata_i[WACK_BIT]),
    .q_o   (warn_q)
  );

  pmu_sticky u_ppd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ppd_exit_i),
    .clr_i (wr & wdata_i[PACK_BIT]),
    .q_o   (ppd_q)
  );

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    pmu_wonce u_wo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr),
      .d_i     (wdata_i[CFG_LSB+i]),
      .q_o     (cfg_q[i]),
      .locked_o(cfg_lock[i])
    );
  end

  assign pd_mode_o = cfg_q[PMODE_BIT-CFG_LSB];
  assign pd_en_o   = cfg_q[PDEN_BIT-CFG_LSB];

  always_comb begin
    reg_val            = '0;
    reg_val[WFLAG_BIT] = warn_q;
    reg_val[PFLAG_BIT] = ppd_q;
    reg_val[PDEN_BIT]  = pd_en_o;
    reg_val[PMODE_BIT] = pd_mode_o;
  end

  assign rdata_o = sel_i ? reg_val : '0;
endmodule

// File: rtl/pmu_stat_ctrl_chk.sv
module pmu_stat_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       ppd_exit_i,
  input logic       pd_en_o,
  input logic       pd_mode_o,
  input logic       lvw_sync,
  input logic       warn_q,
  input logic       ppd_q
);
  logic wr, seen_q;
  assign wr = sel_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  seen_q <= 1'b0;
    else if (wr)  seen_q <= 1'b1;
  end

  assert_warn_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvw_sync |=> warn_q);

  assert_warn_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_q && !(wr && wdata_i[6])) |=> warn_q);

  assert_warn_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wdata_i[6] && !lvw_sync) |=> !warn_q);

  assert_ppd_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppd_exit_i |=> ppd_q);

  assert_ppd_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wdata_i[2] && !ppd_exit_i) |=> !ppd_q);

  assert_first_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !seen_q) |=> (pd_en_o == $past(wdata_i[1]) && pd_mode_o == $past(wdata_i[0])));

  assert_cfg_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> ($stable(pd_en_o) && $stable(pd_mode_o)));

  assert_zero_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[6:4] == 3'b000 && !rdata_o[2] && (sel_i || rdata_o == 8'h00)));
endmodule

bind pmu_stat_ctrl pmu_stat_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .ppd_exit_i(ppd_exit_i),
  .pd_en_o   (pd_en_o),
  .pd_mode_o (pd_mode_o),
  .lvw_sync  (lvw_sync),
  .warn_q    (warn_q),
  .ppd_q     (ppd_q)
);

// File: tb/sim_pmu_stat_ctrl.sv
module sim_pmu_stat_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, we_i = 1'b0, lvw_i = 1'b0, ppd_exit_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       pd_en_o, pd_mode_o;

  int tests = 0, fails = 0;
  logic m_s1, m_s2, m_warn, m_ppd, m_en, m_mode, m_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_stat_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lvw_i(lvw_i),
    .ppd_exit_i(ppd_exit_i), .pd_en_o(pd_en_o), .pd_mode_o(pd_mode_o)
  );

  function automatic logic [7:0] exp_rd(input logic s);
    return s ? {m_warn, 3'b000, m_ppd, 1'b0, m_en, m_mode} : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_s1, m_s2, m_warn, m_ppd, m_en, m_mode, m_lock} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; sel_i = 0; we_i = 0; ppd_exit_i = 0; wdata_i = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // one cycle: drive at negedge, compare before edge, advance model
  task automatic step(input logic s, input logic w, input logic [7:0] d,
                      input logic lv, input logic px, input string tag);
    logic wr;
    sel_i = s; we_i = w; wdata_i = d; lvw_i = lv; ppd_exit_i = px;
    #1;
    chk(tag, rdata_o, exp_rd(s));
    chk(tag, {6'b0, pd_en_o, pd_mode_o}, {6'b0, m_en, m_mode});
    @(posedge clk);
    wr = s & w;
    if (m_s2) m_warn = 1'b1; else if (wr && d[6]) m_warn = 1'b0;
    if (px) m_ppd = 1'b1; else if (wr && d[2]) m_ppd = 1'b0;
    if (wr && !m_lock) begin m_en = d[1]; m_mode = d[0]; m_lock = 1'b1; end
    m_s2 = m_s1; m_s1 = lv;
    @(negedge clk);
  endtask

  task automatic peek(input logic lv, input string tag, input logic [7:0] exp);
    sel_i = 1; we_i = 0; lvw_i = lv; ppd_exit_i = 0;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    do_reset();
    // R4 R9 reset state, deselected reads zero
    peek(0, "R4", 8'h00);
    step(0, 0, 8'h00, 0, 0, "R9");
    // R1 warning through synchronizer
    repeat (3) step(0, 0, 8'h00, 1, 0, "R1");
    peek(1, "R1", 8'h80);
    // R2 sticky after level drops
    repeat (4) step(0, 0, 8'h00, 0, 0, "R2");
    peek(0, "R2", 8'h80);
    // R3 ack while present is ignored, then clears once level low
    repeat (3) step(0, 0, 8'h00, 1, 0, "R3");
    step(1, 1, 8'h40, 1, 0, "R3");
    peek(1, "R3", 8'h80 | {6'b0, pd_en_o, pd_mode_o});
    repeat (3) step(0, 0, 8'h00, 0, 0, "R3");
    step(1, 1, 8'h40, 0, 0, "R3");
    peek(0, "R3", {6'b0, m_en, m_mode});
    // R10 flag positions not writable
    step(1, 1, 8'h88, 0, 0, "R10");
    peek(0, "R10", {6'b0, m_en, m_mode});
    // R5 R6 partial power-down flag
    step(0, 0, 8'h00, 0, 1, "R5");
    repeat (3) step(0, 0, 8'h00, 0, 0, "R5");
    peek(0, "R5", 8'h08 | {6'b0, m_en, m_mode});
    step(1, 1, 8'h04, 0, 0, "R6");
    peek(0, "R6", {6'b0, m_en, m_mode});
    step(1, 1, 8'h04, 0, 1, "R6");
    peek(0, "R6", 8'h08 | {6'b0, m_en, m_mode});
    // R7 R8 write-once: value 10 then attempt 01
    do_reset();
    step(1, 1, 8'h02, 0, 0, "R7");
    chk("R7", {6'b0, pd_en_o, pd_mode_o}, 8'h02);
    step(1, 1, 8'h01, 0, 0, "R8");
    step(1, 1, 8'hFF, 0, 0, "R8");
    chk("R8", {6'b0, pd_en_o, pd_mode_o}, 8'h02);
    // R7 R8 first write of zeros also locks
    do_reset();
    step(1, 1, 8'h00, 0, 0, "R7");
    step(1, 1, 8'h03, 0, 0, "R8");
    chk("R8", {6'b0, pd_en_o, pd_mode_o}, 8'h00);
    // R4 warning comes out of reset set if level held high
    lvw_i = 1'b1;
    do_reset();
    repeat (3) step(0, 0, 8'h00, 1, 0, "R4");
    peek(1, "R4", 8'h80);
    // random phase, checked against the cycle model
    do_reset();
    begin
      logic lv = 0;
      for (int n = 0; n < 3000; n++) begin
        logic s, w, px;
        logic [7:0] d;
        if ($urandom_range(0, 7) == 0) lv = ~lv;
        s  = ($urandom_range(0, 2) != 0);
        w  = ($urandom_range(0, 3) == 0);
        px = ($urandom_range(0, 9) == 0);
        d  = 8'($urandom());
        step(s, w, d, lv, px, "R9");
        if ($urandom_range(0, 499) == 0) do_reset();
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule